// File: doc/BRIEF.md
# Synchronous Serial Frame Receiver with Break Detection

This block receives bytes from a two-wire synchronous link made of a link clock and a data line. Both wires are brought into the system clock domain through flop synchronizers. The block detects the edges of the link clock. It latches the data line on each rising link edge and closes a bit slot on each falling link edge. The slots are assembled into 11-bit frames, and each frame is checked for even parity and for a high stop bit. Only a frame that passes both checks is delivered as a byte.

In parallel, the block counts consecutive low slots without regard to frame boundaries. Once a frame's length of lows has been seen, a break is pending. The break is reported on the first high slot that follows, and any partly assembled frame is dropped. A consumer watches the `valid` strobe for bytes and the error and break strobes for line events. Each strobe is one system clock wide.

Top module: `sync_frame_rx`

## Requirements
- R1: While reset is held and right after it, `valid`, `parity_err`, `stop_err` and `brk` are low and `rx_byte` is zero.
- R2: The data line value used for a slot is the one present at the rising link edge, not one present later in the slot. The first falling link edge after reset only marks a slot boundary, so the slot it closes is never processed.
- R3: A frame is a low start bit, eight data bits sent least significant bit first, a parity bit and a stop bit. A frame with correct parity and a high stop bit gives one `valid` pulse, with the data bits on `rx_byte`.
- R4: Parity is even: when the count of ones over the data bits and the parity bit is odd, `parity_err` pulses once and no byte is delivered.
- R5: A stop bit sampled low pulses `stop_err` once and no byte is delivered. When parity is also wrong, both error flags pulse in the same cycle.
- R6: High slots while waiting for a start bit produce no output. Frames may follow each other directly after a single stop bit or after any number of extra high slots.
- R7: Eleven consecutive low slots, counted across frame boundaries, make a break pending. `brk` stays low for as long as the line stays low, and pulses once on the next high slot.
- R8: A frame of eleven low slots is reported as a break only, with no stop or parity error. Ten consecutive lows (data 0x00, parity 0, stop 1) are a valid byte.
- R9: After a break, frame assembly restarts, and the next start bit begins a fresh frame.
- R10: Every strobe lasts one system clock cycle. `rx_byte` changes only together with `valid` and keeps its value through error frames and breaks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_clk | input | 1 | Link clock, asynchronous to clk |
| link_dat | input | 1 | Link data line |
| valid | output | 1 | One-cycle strobe: a good byte is on rx_byte |
| rx_byte | output | DATA_W | Last delivered byte, held between strobes |
| parity_err | output | 1 | One-cycle strobe: frame failed even parity |
| stop_err | output | 1 | One-cycle strobe: stop bit was low |
| brk | output | 1 | One-cycle strobe: break ended by a high slot |

## Verification
A slot counter or shift register that is out of step shows up within one frame. The byte on `rx_byte` comes out rotated, or parity flags appear on good frames. A wrong zero-run count shows up when a break fires too early, too late or not at all. It also shows up when an all-zero frame gives a stop error instead of a break. An arming flag that never takes effect turns the low slot before the first falling edge into a start bit, which gives a parity error about ten slots later. Each of these appears at the ports a few system cycles after the falling link edge that closes the affected slot.

// File: rtl/sync_frame_rx.sv
module sync_frame_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_clk,
  input  logic              link_dat,
  output logic              valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic              parity_err,
  output logic              stop_err,
  output logic              brk
);
  localparam int FRAME_LEN = DATA_W + 3;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(FRAME_LEN);

  logic [SYNC_STAGES-1:0] ck_sync, dt_sync;
  logic                   ck_q, samp, armed, brk_pend;
  logic [DATA_W:0]        shreg;
  logic [CNT_W-1:0]       nbits, zrun;

  wire ck_s   = ck_sync[SYNC_STAGES-1];
  wire dt_s   = dt_sync[SYNC_STAGES-1];
  wire rise   = ck_s & ~ck_q;
  wire fall   = ~ck_s & ck_q;
  wire bit_go = fall & armed;

  wire [CNT_W-1:0] zrun_nx = samp ? '0 : (zrun == RUN_MAX ? zrun : zrun + 1'b1);
  wire brk_hit  = brk_pend | (zrun_nx == RUN_MAX);
  wire par_bad  = ^shreg;
  wire stop_bad = ~samp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_sync    <= '0;
      dt_sync    <= '0;
      ck_q       <= 1'b0;
      samp       <= 1'b0;
      armed      <= 1'b0;
      brk_pend   <= 1'b0;
      shreg      <= '0;
      nbits      <= '0;
      zrun       <= '0;
      valid      <= 1'b0;
      rx_byte    <= '0;
      parity_err <= 1'b0;
      stop_err   <= 1'b0;
      brk        <= 1'b0;
    end else begin
      ck_sync    <= {ck_sync[SYNC_STAGES-2:0], link_clk};
      dt_sync    <= {dt_sync[SYNC_STAGES-2:0], link_dat};
      ck_q       <= ck_s;
      valid      <= 1'b0;
      parity_err <= 1'b0;
      stop_err   <= 1'b0;
      brk        <= 1'b0;
      if (rise) samp <= dt_s;
      if (fall) armed <= 1'b1;
      if (bit_go) begin
        zrun <= zrun_nx;
        if (brk_hit) begin
          nbits <= '0;
          if (samp) begin
            brk      <= 1'b1;
            brk_pend <= 1'b0;
          end else begin
            brk_pend <= 1'b1;
          end
        end else if (nbits == '0 && samp) begin
          nbits <= '0;
        end else if (nbits == LAST_IDX) begin
          nbits      <= '0;
          valid      <= ~par_bad & ~stop_bad;
          parity_err <= par_bad;
          stop_err   <= stop_bad;
          if (!par_bad && !stop_bad) rx_byte <= shreg[DATA_W-1:0];
        end else begin
          shreg <= {samp, shreg[DATA_W:1]};
          nbits <= nbits + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_frame_rx_chk.sv
module sync_frame_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic [DATA_W-1:0] rx_byte,
  input logic              parity_err,
  input logic              stop_err,
  input logic              brk
);
  assert_clean_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !parity_err);
  assert_clean_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !stop_err);
  assert_brk_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> (!valid && !parity_err && !stop_err));
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_brk_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !brk);
  assert_byte_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> valid);
endmodule

bind sync_frame_rx sync_frame_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .rx_byte(rx_byte),
  .parity_err(parity_err), .stop_err(stop_err), .brk(brk)
);

// File: tb/sim_sync_frame_rx.sv
module sim_sync_frame_rx;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_clk = 1'b0;
  logic link_dat = 1'b1;
  logic valid, parity_err, stop_err, brk;
  logic [7:0] rx_byte;

  int total = 0, fails = 0;
  int nv = 0, npe = 0, nse = 0, nbk = 0;
  int sv, spe, sse, sbk;
  bit done = 0;

  always #5 clk = ~clk;

  sync_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .link_dat(link_dat),
    .valid(valid), .rx_byte(rx_byte), .parity_err(parity_err),
    .stop_err(stop_err), .brk(brk)
  );

  always @(negedge clk) if (rst_n) begin
    if (valid) nv++;
    if (parity_err) npe++;
    if (stop_err) nse++;
    if (brk) nbk++;
  end

  // {data, parity, stop, exp_valid, exp_perr, exp_serr}
  localparam logic [12:0] VEC [7] = '{
    {8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h7E, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) link_dat = b;
    repeat (HALF) @(negedge clk);
    link_clk = 1'b1;
    repeat (HALF/2) @(negedge clk);
    link_dat = ~b;
    repeat (HALF/2) @(negedge clk);
    link_clk = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic p, input logic s);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(p);
    send_bit(s);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic snap();
    sv = nv; spe = npe; sse = nse; sbk = nbk;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_rx;
    repeat (4) @(negedge clk);
    chk(valid === 1'b0, "R1 valid in reset", valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0 && brk === 1'b0, "R1 valid/brk after reset", {valid, brk}, 0);
    chk(parity_err === 1'b0 && stop_err === 1'b0, "R1 error flags after reset", {parity_err, stop_err}, 0);
    chk(rx_byte === 8'h00, "R1 rx_byte after reset", rx_byte, 0);

    // R2: low slot before the first falling edge must not start a frame
    snap();
    send_bit(1'b0);
    repeat (10) send_bit(1'b1);
    settle();
    chk(npe == spe && nv == sv, "R2 unarmed slot ignored", npe - spe, 0);
    chk(nse == sse && nbk == sbk, "R6 idle highs ignored", nse - sse + nbk - sbk, 0);

    exp_rx = 8'h00;
    for (int i = 0; i < 7; i++) begin
      logic [12:0] v;
      v = VEC[i];
      snap();
      send_frame(v[12:5], v[4], v[3]);
      for (int k = 0; k < i % 3; k++) send_bit(1'b1);
      settle();
      if (v[2]) exp_rx = v[12:5];
      chk(nv - sv == int'(v[2]), "R3 valid pulse count", nv - sv, v[2]);
      chk(npe - spe == int'(v[1]), "R4 parity_err count", npe - spe, v[1]);
      chk(nse - sse == int'(v[0]), "R5 stop_err count", nse - sse, v[0]);
      chk(nbk == sbk, "R6 no break on frame", nbk - sbk, 0);
      chk(rx_byte === exp_rx, "R10 rx_byte value", rx_byte, exp_rx);
    end

    // R7: break pending while low, reported on high
    snap();
    repeat (14) send_bit(1'b0);
    settle();
    chk(nbk == sbk, "R7 no brk while low", nbk - sbk, 0);
    send_bit(1'b1);
    settle();
    chk(nbk - sbk == 1, "R7 brk on return high", nbk - sbk, 1);
    chk(nv == sv && nse == sse && npe == spe, "R7 brk only", nv - sv + nse - sse, 0);

    // R8: eleven-zero frame is a break, not a stop error
    snap();
    send_frame(8'h00, 1'b0, 1'b0);
    send_bit(1'b1);
    settle();
    chk(nbk - sbk == 1, "R8 zero frame brk", nbk - sbk, 1);
    chk(nse == sse && npe == spe, "R8 zero frame no error", nse - sse, 0);

    // R7/R9: misaligned break, then fresh frame
    snap();
    send_frame(8'h0F, 1'b0, 1'b0);
    repeat (5) send_bit(1'b0);
    settle();
    chk(nse - sse == 1 && nbk == sbk, "R7 misaligned run pending", nbk - sbk, 0);
    chk(rx_byte === 8'h7E, "R10 rx_byte held", rx_byte, 8'h7E);
    send_bit(1'b1);
    settle();
    chk(nbk - sbk == 1, "R7 misaligned brk", nbk - sbk, 1);
    snap();
    send_frame(8'h5A, 1'b0, 1'b1);
    send_bit(1'b1);
    settle();
    chk(nv - sv == 1 && rx_byte === 8'h5A, "R9 frame after break", rx_byte, 8'h5A);

    done = 1;
    summary();
    $finish;
  end
endmodule